// File: doc/BRIEF.md
# Two-Phase Shared-Multiplier FIR Filter

This block is an 8-tap finite impulse response filter that needs only four signed multipliers. It runs on a single clock at twice the sample rate. A new input sample arrives on every second cycle, marked by a one-cycle strobe. Each sample period is split into two compute phases, and the same four-lane multiply-add unit serves both.

In the sample cycle, the odd-indexed coefficients are applied to the odd-delayed history, and the result goes into a partial-sum register. In the next cycle, the even-indexed coefficients are applied to the current sample and the even-delayed history. That sum is added to the stored partial, and the total is registered as the filter output, together with a one-cycle valid flag.

The coefficients are fixed constants held in a small two-entry ROM, one entry for each phase. Data and coefficients are signed two's complement. The output is kept at full precision, with no rounding or saturation.

Top module: `tdm_fir_top`

## Requirements
- R1: A synchronous active-high reset drives `out_valid` and `y` to zero and clears the sample history and the partial sum. The first output after reset therefore depends only on samples presented after reset.
- R2: Each output equals y(n) = sum over k = 0..7 of h(k)·x(n−k). Here x(n) is the sample presented with the strobe that produced this output, x(n−k) is the sample k strobes earlier, and the coefficients are h0=1234, h1=−2345, h2=31000, h3=−131072, h4=131071, h5=−7, h6=500, h7=−60000.
- R3: `out_valid` is high for exactly one cycle. That cycle is the second cycle after the cycle in which `in_valid` was high, so one output follows each sample.
- R4: The sample cycle produces no output. `out_valid` is low in the cycle right after a sample cycle, and in that cycle the odd-tap partial sum is held internally.
- R5: Inputs and coefficients are 18-bit signed. The 39-bit output holds every possible sum without overflow, including when all inputs sit at −131072 or alternate between the 18-bit extremes.
- R6: The history advances only on cycles where `in_valid` is high. Idle cycles of any length between samples leave the result of the next sample unchanged.
- R7: `y` holds its value on every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe, never high on two consecutive cycles |
| din | input | 18 | Signed input sample, read when `in_valid` is high |
| out_valid | output | 1 | One-cycle flag marking a new output |
| y | output | 39 | Signed filter output, full precision |

## Verification
The assertions assume that `in_valid` is never high on two consecutive cycles. Without that spacing, the even phase of one sample would collide with the odd phase of the next.

The assertions also assume that reset is held for at least two cycles, so that history-based checks start from cleared values.

The bench drives every sample through a task that raises the strobe for one cycle and drops it for at least the next, and it holds reset for several cycles. Idle stretches longer than one cycle are added on purpose, because they stay inside that assumption.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;

  localparam int DATA_W = 18;
  localparam int COEF_W = 18;
  localparam int LANES  = 4;
  localparam int PROD_W = DATA_W + COEF_W;

  typedef enum logic {PH_ODD = 1'b0, PH_EVEN = 1'b1} phase_e;

  // Fixed tap weights, indexed by tap number
  function automatic logic signed [COEF_W-1:0] tap_coef(input int k);
    logic signed [COEF_W-1:0] c;
    case (k)
      0: c = 18'sd1234;
      1: c = -18'sd2345;
      2: c = 18'sd31000;
      3: c = -18'sd131072;
      4: c = 18'sd131071;
      5: c = -18'sd7;
      6: c = 18'sd500;
      7: c = -18'sd60000;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Full-precision signed product of one lane
  function automatic logic signed [PROD_W-1:0] lane_product(
    input logic signed [DATA_W-1:0] a,
    input logic signed [COEF_W-1:0] c
  );
    return PROD_W'(a) * PROD_W'(c);
  endfunction

endpackage

// File: rtl/tdm_fir_delay.sv
module tdm_fir_delay #(
  parameter int DATA_W = tdm_fir_pkg::DATA_W,
  parameter int DEPTH  = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shift_en,
  input  logic [DATA_W-1:0]             din,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

  logic [DEPTH-1:0][DATA_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  assign taps = hist_q;

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));

  // R6
  hist_step_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[0] == $past(din));

endmodule

// File: rtl/tdm_fir_coef_rom.sv
module tdm_fir_coef_rom
  import tdm_fir_pkg::*;
#(
  parameter int LANES = tdm_fir_pkg::LANES
) (
  input  phase_e                          phase,
  output logic [LANES-1:0][COEF_W-1:0]    coefs
);

  // Odd phase: entry of odd taps; even phase: entry of even taps
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int EVEN_TAP = 2 * i;
    localparam int ODD_TAP  = 2 * i + 1;
    assign coefs[i] = (phase == PH_EVEN) ? tap_coef(EVEN_TAP) : tap_coef(ODD_TAP);
  end

endmodule

// File: rtl/tdm_fir_mac.sv
module tdm_fir_mac
  import tdm_fir_pkg::*;
#(
  parameter int LANES = tdm_fir_pkg::LANES,
  localparam int SUM_W = PROD_W + $clog2(LANES)
) (
  input  logic [LANES-1:0][DATA_W-1:0]  data,
  input  logic [LANES-1:0][COEF_W-1:0]  coefs,
  output logic signed [SUM_W-1:0]       sum
);

  logic [LANES-1:0][PROD_W-1:0] prod;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    assign prod[i] = lane_product($signed(data[i]), $signed(coefs[i]));
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++)
      sum = sum + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
  end

endmodule

// File: rtl/tdm_fir_top.sv
module tdm_fir_top
  import tdm_fir_pkg::*;
#(
  parameter int LANES = tdm_fir_pkg::LANES,
  localparam int TAPS  = 2 * LANES,
  localparam int DEPTH = TAPS - 1,
  localparam int SUM_W = PROD_W + $clog2(LANES),
  localparam int ACC_W = PROD_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        din,
  output logic                     out_valid,
  output logic [ACC_W-1:0]         y
);

  logic even_phase_q;
  phase_e phase;
  logic [DEPTH-1:0][DATA_W-1:0] taps;
  logic [LANES-1:0][DATA_W-1:0] lane_data;
  logic [LANES-1:0][COEF_W-1:0] lane_coefs;
  logic signed [SUM_W-1:0] lane_sum;
  logic signed [SUM_W-1:0] partial_q;
  logic [ACC_W-1:0] y_q;
  logic out_valid_q;

  // Named internal events
  logic odd_event;
  logic even_event;
  assign odd_event  = in_valid;
  assign even_event = even_phase_q;

  assign phase = even_phase_q ? PH_EVEN : PH_ODD;

  tdm_fir_delay #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(din), .taps(taps)
  );

  // Both phases read the same even-indexed stored slots:
  // before the shift they are x(n-1),x(n-3)..; after it x(n),x(n-2)..
  for (genvar i = 0; i < LANES; i++) begin : g_pick
    assign lane_data[i] = taps[2*i];
  end

  tdm_fir_coef_rom #(.LANES(LANES)) u_rom (
    .phase(phase), .coefs(lane_coefs)
  );

  tdm_fir_mac #(.LANES(LANES)) u_mac (
    .data(lane_data), .coefs(lane_coefs), .sum(lane_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      even_phase_q <= 1'b0;
      partial_q    <= '0;
      y_q          <= '0;
      out_valid_q  <= 1'b0;
    end else begin
      even_phase_q <= odd_event;
      out_valid_q  <= even_event;
      if (odd_event) partial_q <= lane_sum;
      if (even_event)
        y_q <= {{(ACC_W-SUM_W){partial_q[SUM_W-1]}}, partial_q}
             + {{(ACC_W-SUM_W){lane_sum[SUM_W-1]}}, lane_sum};
    end
  end

  assign out_valid = out_valid_q;
  assign y         = y_q;

  // input assumption: strobe spacing
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !in_valid);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && y == '0 && partial_q == '0));

  // R3
  ov_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R3
  ov_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4
  no_odd_output_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !out_valid);

  // R4
  partial_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(partial_q));

  // R7
  y_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(y));

endmodule

// File: tb/tb_tdm_fir_top.sv
module tb_tdm_fir_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [17:0] din = '0;
  logic out_valid;
  logic [38:0] y;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  longint hist [8];
  localparam longint H [8] = '{1234, -2345, 31000, -131072, 131071, -7, 500, -60000};

  always #5 clk = ~clk;

  tdm_fir_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .din(din),
    .out_valid(out_valid), .y(y)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint y_val();
    return longint'($signed(y));
  endfunction

  function automatic longint ref_out();
    longint s = 0;
    for (int k = 0; k < 8; k++) s += H[k] * hist[k];
    return s;
  endfunction

  task automatic clear_model();
    for (int k = 0; k < 8; k++) hist[k] = 0;
  endtask

  // Starts and ends at a falling edge; one output per call
  task automatic send(input logic signed [17:0] x, input string req);
    longint exp;
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(x);
    exp = ref_out();
    in_valid = 1'b1;
    din = x;
    @(negedge clk);
    in_valid = 1'b0;
    din = '0;
    check(out_valid == 1'b0, "R4", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R3", longint'(out_valid), 1);
    check(y_val() == exp, req, y_val(), exp);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    check(y_val() == 0, "R1", y_val(), 0);
    rst = 1'b0;
    clear_model();
  endtask

  task automatic test_impulse();
    send(18'sd1, "R2");
    for (int i = 0; i < 9; i++) send(18'sd0, "R2");
    send(-18'sd1, "R2");
    for (int i = 0; i < 8; i++) send(18'sd0, "R2");
  endtask

  task automatic test_random();
    for (int i = 0; i < 60; i++) send(18'($urandom), "R2");
  endtask

  task automatic test_extremes();
    for (int i = 0; i < 10; i++) send(-18'sd131072, "R5");
    for (int i = 0; i < 10; i++) send(18'sd131071, "R5");
    for (int i = 0; i < 16; i++)
      send((i % 2 == 0) ? 18'sd131071 : -18'sd131072, "R5");
  endtask

  task automatic test_gaps();
    longint held;
    for (int g = 1; g < 7; g++) begin
      send(18'($urandom), "R6");
      held = y_val();
      repeat (g) begin
        @(negedge clk);
        check(out_valid == 1'b0, "R7", longint'(out_valid), 0);
        check(y_val() == held, "R7", y_val(), held);
      end
      send(18'($urandom), "R6");
    end
  endtask

  task automatic test_midstream_reset();
    for (int i = 0; i < 8; i++) send(18'sd50000, "R2");
    test_reset();
    send(18'sd3, "R1");
    send(18'sd0, "R1");
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_impulse();
    test_random();
    test_extremes();
    test_gaps();
    test_midstream_reset();
    test_random();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule